// File: doc/BRIEF.md
# I2C Bus Condition Monitor

This block observes the clock and data lines of an I2C bus. Both lines arrive already synchronized to the system clock. The block recognizes START and STOP conditions and keeps one status flag for each. At any time only the most recent of the two conditions is marked. From these flags it derives a bus-free indication, which firmware or a master engine uses to decide when it may take control of the bus.

The block also keeps a sticky event flag for interrupts. The flag is raised by a START, by a STOP, or by a byte-complete strobe from a separate shift engine. It stays raised until software clears it. When the bus is busy at the time interrupts are turned on, the next event seen is the STOP that frees the bus, or a byte completion.

Data shifting, address matching and clock stretching belong to other blocks.

Top module: `i2c_cond_mon`

## Requirements
- R1: After reset `start_flag_o`, `stop_flag_o` and `irq_o` are 0 and `bus_free_o` is 1.
- R2: A START is recorded when SCL is high in both the previous and the current sample and SDA goes from 1 to 0. One clock edge later `start_flag_o` is 1 and `stop_flag_o` is 0.
- R3: A STOP is recorded when SCL is high in both the previous and the current sample and SDA goes from 0 to 1. One clock edge later `stop_flag_o` is 1 and `start_flag_o` is 0.
- R4: `bus_free_o` is 1 exactly when `stop_flag_o` is 1 or when both flags are 0.
- R5: `irq_o` becomes 1 one clock edge after a START, after a STOP, or after `byte_done_i` is sampled high while the block is enabled.
- R6: `irq_o` stays at 1 until `irq_clr_i` is sampled high. If a clear and a new event fall in the same cycle, `irq_o` stays 1.
- R7: While `en_i` is 0, both flags are held at 0, and line activity and `byte_done_i` have no effect. `irq_o` keeps its value while the block is disabled.
- R8: When the block is re-enabled after line levels changed during the disabled period, no condition is recorded.
- R9: An SDA change while SCL is low records no condition and changes neither flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Module enable |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| byte_done_i | input | 1 | Single-cycle strobe from the shift engine when a byte completes |
| irq_clr_i | input | 1 | Software clear of the interrupt flag |
| start_flag_o | output | 1 | A START was the last condition seen |
| stop_flag_o | output | 1 | A STOP was the last condition seen |
| bus_free_o | output | 1 | The bus may be taken |
| irq_o | output | 1 | Sticky event flag |

## Verification
The assertions assume that `scl_i` and `sda_i` are clean, synchronized levels that hold for at least one clock. They also assume that `byte_done_i` is a single-cycle pulse. The stimulus changes line levels only on the falling clock edge and never changes both lines in the same cycle, except when it deliberately exercises a disabled period. Strobes are raised for exactly one cycle. The only exception is the vector that shows a strobe being ignored while the block is disabled.

// File: rtl/i2c_cond_mon_pkg.sv
package i2c_cond_mon_pkg;
  localparam int unsigned EVT_W = 3;

  typedef enum logic [1:0] {
    EVT_START = 2'd0,
    EVT_STOP  = 2'd1,
    EVT_BYTE  = 2'd2
  } evt_idx_e;

  typedef struct packed {
    logic scl;
    logic sda;
  } line_s;
endpackage

// File: rtl/i2c_line_edge.sv
module i2c_line_edge
  import i2c_cond_mon_pkg::*;
#(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  line_s line_i,
  output logic  start_det_o,
  output logic  stop_det_o
);
  line_s prev_q;

  // tracks lines always, so enabling reloads the history
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '{scl: IDLE_LVL, sda: IDLE_LVL};
    else         prev_q <= line_i;
  end

  logic scl_hi;
  assign scl_hi      = prev_q.scl & line_i.scl;
  assign start_det_o = en_i & scl_hi &  prev_q.sda & ~line_i.sda;
  assign stop_det_o  = en_i & scl_hi & ~prev_q.sda &  line_i.sda;

  a_r2_no_start_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !start_det_o && !stop_det_o);
  a_r9_scl_low_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_i.scl |-> !start_det_o && !stop_det_o);
endmodule

// File: rtl/i2c_cond_flags.sv
module i2c_cond_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic start_det_i,
  input  logic stop_det_i,
  output logic start_flag_o,
  output logic stop_flag_o
);
  logic start_q, stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else if (!en_i) begin
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else if (start_det_i) begin
      start_q <= 1'b1;
      stop_q  <= 1'b0;
    end else if (stop_det_i) begin
      start_q <= 1'b0;
      stop_q  <= 1'b1;
    end
  end

  assign start_flag_o = start_q;
  assign stop_flag_o  = stop_q;

  a_r7_off_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !start_flag_o && !stop_flag_o);
  a_r2_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_flag_o && stop_flag_o));
  a_r3_stop_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && stop_det_i |=> stop_flag_o);
endmodule

// File: rtl/i2c_evt_irq.sv
module i2c_evt_irq
  import i2c_cond_mon_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             clr_i,
  output logic             irq_o
);
  logic [EVT_W-1:0] evt_or;
  logic             irq_q;

  for (genvar g = 0; g < EVT_W; g++) begin : g_red
    if (g == 0) begin : g_first
      assign evt_or[g] = evt_i[g];
    end else begin : g_rest
      assign evt_or[g] = evt_or[g-1] | evt_i[g];
    end
  end

  // event wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                irq_q <= 1'b0;
    else if (evt_or[EVT_W-1])   irq_q <= 1'b1;
    else if (clr_i)             irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  a_r5_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |evt_i |=> irq_o);
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !clr_i |=> irq_o);
  a_r6_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o && !(|evt_i) |=> !irq_o);
endmodule

// File: rtl/i2c_cond_mon.sv
module i2c_cond_mon
  import i2c_cond_mon_pkg::*;
#(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic scl_i,
  input  logic sda_i,
  input  logic byte_done_i,
  input  logic irq_clr_i,
  output logic start_flag_o,
  output logic stop_flag_o,
  output logic bus_free_o,
  output logic irq_o
);
  line_s            line;
  logic             start_det, stop_det;
  logic [EVT_W-1:0] evt;

  assign line = '{scl: scl_i, sda: sda_i};

  i2c_line_edge #(.IDLE_LVL(IDLE_LVL)) i_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .line_i      (line),
    .start_det_o (start_det),
    .stop_det_o  (stop_det)
  );

  i2c_cond_flags i_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .start_det_i  (start_det),
    .stop_det_i   (stop_det),
    .start_flag_o (start_flag_o),
    .stop_flag_o  (stop_flag_o)
  );

  always_comb begin
    evt            = '0;
    evt[EVT_START] = start_det;
    evt[EVT_STOP]  = stop_det;
    evt[EVT_BYTE]  = byte_done_i & en_i;
  end

  i2c_evt_irq i_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .clr_i  (irq_clr_i),
    .irq_o  (irq_o)
  );

  assign bus_free_o = stop_flag_o | ~start_flag_o;

  a_r4_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !bus_free_o);
  a_r4_stop_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> bus_free_o);
endmodule

// File: tb/test_i2c_cond_mon.sv
module test_i2c_cond_mon;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en, scl, sda, bd, clr;
  logic st, sp, fr, irq;
  int   checks = 0;
  int   errors = 0;

  always #5 clk = ~clk;

  i2c_cond_mon i_i2c_cond_mon (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .scl_i(scl), .sda_i(sda),
    .byte_done_i(bd), .irq_clr_i(clr), .start_flag_o(st), .stop_flag_o(sp),
    .bus_free_o(fr), .irq_o(irq)
  );

  // {en,scl,sda,bd,clr, exp start,stop,free,irq}
  localparam int NV = 18;
  localparam logic [8:0] VEC [NV] = '{
    9'b11100_0010, // R4 idle free
    9'b11000_1001, // R2 R5 start
    9'b10000_1001,
    9'b10101_1000, // R9 sda rises with scl low; R6 clear
    9'b11100_1000, // R9
    9'b10110_1001, // R5 byte done
    9'b10001_1000,
    9'b11000_1000,
    9'b11100_0111, // R3 R5 stop
    9'b11001_1001, // R6 clear with start same cycle
    9'b11100_0111,
    9'b11101_0110,
    9'b01100_0010, // R7 disable clears
    9'b01000_0010, // R7 sda fall ignored
    9'b01010_0010, // R7 byte done ignored
    9'b11000_0010, // R8 enable, no false condition
    9'b11100_0111, // R3
    9'b10100_0111
  };

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual st/sp/free/irq=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(logic [4:0] in);
    @(negedge clk);
    {en, scl, sda, bd, clr} = in;
    @(posedge clk);
    #1;
  endtask

  initial begin
    {en, scl, sda, bd, clr} = 5'b11100;
    #1;
    check("R1", {st, sp, fr, irq}, 4'b0010);
    #20 rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][8:4]);
      check($sformatf("vec%0d R2-R9", i), {st, sp, fr, irq}, VEC[i][3:0]);
    end
    // R1: reset mid-transfer
    step(5'b11100);
    step(5'b11000);
    check("R2", {st, sp, fr, irq}, 4'b1001);
    @(negedge clk); rst_ni = 1'b0; #1;
    check("R1", {st, sp, fr, irq}, 4'b0010);
    @(negedge clk); rst_ni = 1'b1;
    // R7: irq held across disable
    step(5'b11100);
    step(5'b11000);
    step(5'b01000);
    check("R7", {st, sp, fr, irq}, 4'b0011);
    // R8: both lines change while disabled, then enable
    step(5'b00100);
    step(5'b11101);
    check("R8", {st, sp, fr, irq}, 4'b0010);
    step(5'b11100);
    check("R8", {st, sp, fr, irq}, 4'b0010);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule